// File: doc/BRIEF.md
# Transceiver Interrupt Source Controller

This block turns the status lines of a serial transceiver into three interrupt requests: a receiver request, a transmitter request and a line turn-around request. It combines them into one CPU interrupt line and a 16-bit vector. Each request is held in a latched flag. A flag is set when its status input rises, and it is cleared by the register access that services it. Most flags are cleared by a read or write of the data register, or by a read of the error code register. The line turn-around flag can also be cleared by writing a one to its clear strobe, and a transceiver reset acts on all flags.

A 2-bit select field picks which latched receiver conditions drive the receiver request. The flags themselves keep latching whatever the select field says, so changing the field only changes which flags can interrupt. When more than one request is pending, the receiver wins, then the transmitter, then line turn-around. The vector places an 8-bit base value above two zero bits and a 6-bit offset that belongs to the winning source.

All pins are plain control and status levels or single-cycle strobes. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure. Every output is valid in every cycle.

Top module: `xcvr_irq_ctrl`

## Requirements
- R1: Priority is fixed, with receiver above transmitter above line turn-around. The low 6 bits of `vector` are 6'b000100 for receiver, 6'b001000 for transmitter and 6'b001100 for line turn-around.
- R2: `irq` is high exactly when any of `req_rx`, `req_tx`, `req_lta` is high. In that case `vector` = {`ibase`, 2'b00, offset of the winner}. Otherwise `vector` is 0.
- R3: `rx_sel` decodes the receiver request as follows:
  - 2'b00: FIFO-full flag OR error flag
  - 2'b01: data-available flag OR error flag
  - 2'b10: never
  - 2'b11: start-sequence flag

  The flags keep latching whatever the value of `rx_sel`.
- R4: The FIFO-full and data-available flags clear on `acc_rd_data` and are not cleared by `acc_rd_err`. The error flag clears on `acc_rd_err` and is not cleared by `acc_rd_data`.
- R5: The start-sequence flag clears on either `acc_rd_data` or `acc_rd_err`.
- R6: The transmitter flag sets on a rising edge of `st_tx_empty` and clears on `acc_wr_data`.
- R7: A `xcvr_rst` cycle clears every receiver flag and the line turn-around flag, and sets the transmitter flag. It wins over any set or clear in the same cycle.
- R8: The line turn-around flag sets on a rising edge of `st_end_seq`. It clears on `acc_wr_data` or on `acc_lta_w1c`.
- R9: While `addr_filter_en` is 1 and `addr_match` is 0, a rising edge of `st_end_seq` does not set the line turn-around flag.
- R10: If a flag's set edge and one of its access clears fall in the same cycle, the flag ends up set.
- R11: A flag sets only on a 0-to-1 transition of its status input. A status input that stays high does not set the flag again after it has been cleared.
- R12: Every flag updates on the clock edge at which its cause is sampled, and the outputs follow it without further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_sel | input | 2 | Receiver request source select |
| ibase | input | 8 | Interrupt base value, the top byte of the vector |
| addr_filter_en | input | 1 | Address-filtered mode; gates line turn-around on a match |
| addr_match | input | 1 | An address match has been received |
| st_rx_full | input | 1 | Receive FIFO full |
| st_rx_avail | input | 1 | Receive data available |
| st_rx_err | input | 1 | Receive error detected |
| st_rx_start | input | 1 | Valid start sequence received |
| st_tx_empty | input | 1 | Transmit FIFO empty |
| st_end_seq | input | 1 | Valid end sequence detected |
| acc_rd_data | input | 1 | Data register read strobe |
| acc_wr_data | input | 1 | Data register write strobe |
| acc_rd_err | input | 1 | Error code register read strobe |
| acc_lta_w1c | input | 1 | Write-one-to-clear strobe for line turn-around |
| xcvr_rst | input | 1 | Transceiver reset strobe |
| irq | output | 1 | Any request pending |
| vector | output | 16 | Vector of the winning request |
| req_rx | output | 1 | Receiver request |
| req_tx | output | 1 | Transmitter request |
| req_lta | output | 1 | Line turn-around request |

## Verification
The clocked properties assume that every strobe and status input is a synchronous level that is stable around the clock edge. They also assume that `rx_sel` and `ibase` change only between edges. The bench drives all inputs a short delay after the rising edge and holds strobes for exactly one cycle. It raises a status input and a clear strobe together only in the deliberate same-cycle race cases. Status inputs return low before they are raised again, so that every intended set is a true rising edge, except in the case that holds `st_tx_empty` high on purpose.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int NSRC   = 3;
  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;
  localparam int SRC_LT = 2;
  localparam int BASE_W = 8;
  localparam int PAD_W  = 2;
  localparam int OFF_W  = 6;
  localparam int VEC_W  = BASE_W + PAD_W + OFF_W;

  typedef enum logic [1:0] {
    SEL_FULL  = 2'b00,
    SEL_AVAIL = 2'b01,
    SEL_RSVD  = 2'b10,
    SEL_START = 2'b11
  } rx_sel_e;

  // Offsets step by four per source in priority order.
  function automatic logic [OFF_W-1:0] src_offset(input int idx);
    return OFF_W'((idx + 1) * 4);
  endfunction
endpackage

// File: rtl/xirq_flag.sv
module xirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic stat,
  input  logic gate,
  input  logic clr,
  input  logic force_set,
  input  logic force_clr,
  output logic q
);
  logic prev;
  logic rise;

  assign rise = stat & ~prev & gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      q    <= 1'b0;
    end else begin
      prev <= stat;
      if (force_clr)              q <= 1'b0;
      else if (force_set || rise) q <= 1'b1;
      else if (clr)               q <= 1'b0;
    end
  end

  // R10: a set edge survives a same-cycle access clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rise && !force_clr) |-> q);
  // R4: an access clear without a competing set drops the flag
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr && !rise && !force_set) |-> !q);
  // R7: transceiver reset clears
  a_r7_force_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_clr) |-> !q);
  // R11: no set without an edge
  a_r11_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!q) && $past(!rise) && $past(!force_set)) |-> !q);
endmodule

// File: rtl/xirq_rx_mux.sv
module xirq_rx_mux
  import xirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       full_q,
  input  logic       avail_q,
  input  logic       err_q,
  input  logic       start_q,
  output logic       req
);
  rx_sel_e sel_e;
  assign sel_e = rx_sel_e'(sel);

  always_comb begin
    unique case (sel_e)
      SEL_FULL:  req = full_q | err_q;
      SEL_AVAIL: req = avail_q | err_q;
      SEL_START: req = start_q;
      default:   req = 1'b0;
    endcase
  end

  // R3: reserved code never requests
  a_r3_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b10) |-> !req);
  // R3: error flag always reaches the request in codes 00 and 01
  a_r3_err_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !sel[1]) |-> req);
endmodule

// File: rtl/xirq_vec.sv
module xirq_vec
  import xirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   pend,
  input  logic [BASE_W-1:0] base,
  output logic              irq,
  output logic [VEC_W-1:0]  vec
);
  logic [OFF_W-1:0] off;
  logic             any;

  always_comb begin
    any = 1'b0;
    off = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        off = src_offset(i);
      end
    end
  end

  assign irq = any;
  assign vec = any ? {base, {PAD_W{1'b0}}, off} : '0;

  // R1: highest-priority pending source owns the offset
  a_r1_rx_first: assert property (@(posedge clk) disable iff (!rst_n)
    pend[SRC_RX] |-> (vec[OFF_W-1:0] == 6'b000100));
  a_r1_tx_second: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[SRC_TX] && !pend[SRC_RX]) |-> (vec[OFF_W-1:0] == 6'b001000));
  // R2: idle vector is zero and the base sits on top when pending
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (vec == '0));
  a_r2_base_top: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vec[VEC_W-1 -: BASE_W] == base));
endmodule

// File: rtl/xcvr_irq_ctrl.sv
module xcvr_irq_ctrl
  import xirq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  rx_sel,
  input  logic [7:0]  ibase,
  input  logic        addr_filter_en,
  input  logic        addr_match,
  input  logic        st_rx_full,
  input  logic        st_rx_avail,
  input  logic        st_rx_err,
  input  logic        st_rx_start,
  input  logic        st_tx_empty,
  input  logic        st_end_seq,
  input  logic        acc_rd_data,
  input  logic        acc_wr_data,
  input  logic        acc_rd_err,
  input  logic        acc_lta_w1c,
  input  logic        xcvr_rst,
  output logic        irq,
  output logic [15:0] vector,
  output logic        req_rx,
  output logic        req_tx,
  output logic        req_lta
);
  localparam int NRXF = 4;
  localparam int F_FULL = 0, F_AVAIL = 1, F_ERR = 2, F_START = 3;

  logic [NRXF-1:0] rx_stat, rx_clr, rx_q;
  logic            tx_q, lt_q, lt_gate;
  logic [NSRC-1:0] pend;

  assign rx_stat = {st_rx_start, st_rx_err, st_rx_avail, st_rx_full};
  assign rx_clr[F_FULL]  = acc_rd_data;
  assign rx_clr[F_AVAIL] = acc_rd_data;
  assign rx_clr[F_ERR]   = acc_rd_err;
  assign rx_clr[F_START] = acc_rd_data | acc_rd_err;

  for (genvar g = 0; g < NRXF; g++) begin : g_rxf
    xirq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .stat(rx_stat[g]), .gate(1'b1),
      .clr(rx_clr[g]), .force_set(1'b0), .force_clr(xcvr_rst), .q(rx_q[g])
    );
  end

  xirq_flag u_tx (
    .clk(clk), .rst_n(rst_n), .stat(st_tx_empty), .gate(1'b1),
    .clr(acc_wr_data), .force_set(xcvr_rst), .force_clr(1'b0), .q(tx_q)
  );

  assign lt_gate = ~addr_filter_en | addr_match;

  xirq_flag u_lt (
    .clk(clk), .rst_n(rst_n), .stat(st_end_seq), .gate(lt_gate),
    .clr(acc_wr_data | acc_lta_w1c), .force_set(1'b0), .force_clr(xcvr_rst),
    .q(lt_q)
  );

  xirq_rx_mux u_mux (
    .clk(clk), .rst_n(rst_n), .sel(rx_sel),
    .full_q(rx_q[F_FULL]), .avail_q(rx_q[F_AVAIL]),
    .err_q(rx_q[F_ERR]), .start_q(rx_q[F_START]), .req(req_rx)
  );

  assign req_tx  = tx_q;
  assign req_lta = lt_q;
  assign pend[SRC_RX] = req_rx;
  assign pend[SRC_TX] = req_tx;
  assign pend[SRC_LT] = req_lta;

  xirq_vec u_vec (
    .clk(clk), .rst_n(rst_n), .pend(pend), .base(ibase),
    .irq(irq), .vec(vector)
  );

  // R7: after a transceiver reset only the transmitter request remains
  a_r7_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $past(xcvr_rst) |-> (!req_lta && req_tx && rx_q == '0));
  // R9: filtered mode without a match cannot raise line turn-around
  a_r9_filter_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!req_lta) && $past(addr_filter_en && !addr_match)) |-> !req_lta);
  // R2: irq reflects any request
  a_r2_irq_any: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (req_rx | req_tx | req_lta));
endmodule

// File: tb/xcvr_irq_ctrl_tb.sv
module xcvr_irq_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] rx_sel = 0;
  logic [7:0] ibase = 8'hA5;
  logic addr_filter_en = 0, addr_match = 0;
  logic st_rx_full = 0, st_rx_avail = 0, st_rx_err = 0, st_rx_start = 0;
  logic st_tx_empty = 0, st_end_seq = 0;
  logic acc_rd_data = 0, acc_wr_data = 0, acc_rd_err = 0, acc_lta_w1c = 0;
  logic xcvr_rst = 0;
  logic irq, req_rx, req_tx, req_lta;
  logic [15:0] vector;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  xcvr_irq_ctrl u_dut (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] vx(input logic [5:0] off);
    return {ibase, 2'b00, off};
  endfunction

  task automatic t_reset();
    chk("R2 reset irq", {15'd0, irq}, 16'd0);
    chk("R2 reset vector", vector, 16'd0);
    chk("R2 reset reqs", {13'd0, req_rx, req_tx, req_lta}, 16'd0);
  endtask

  task automatic t_select();
    rx_sel = 2'b00; st_rx_avail = 1; step(); st_rx_avail = 0; step();
    chk("R3 avail masked by 00", {15'd0, req_rx}, 16'd0);
    rx_sel = 2'b01; #1;
    chk("R3 avail under 01", {15'd0, req_rx}, 16'd1);
    chk("R1 rx vector", vector, vx(6'b000100));
    rx_sel = 2'b10; #1;
    chk("R3 reserved", {15'd0, req_rx}, 16'd0);
    rx_sel = 2'b01; acc_rd_data = 1; step(); acc_rd_data = 0;
    chk("R4 avail cleared by data read", {15'd0, req_rx}, 16'd0);
    rx_sel = 2'b11; st_rx_start = 1; step(); st_rx_start = 0;
    chk("R12 R3 start under 11", {15'd0, req_rx}, 16'd1);
    acc_rd_err = 1; step(); acc_rd_err = 0;
    chk("R5 start cleared by error read", {15'd0, req_rx}, 16'd0);
    st_rx_start = 1; step(); st_rx_start = 0;
    acc_rd_data = 1; step(); acc_rd_data = 0;
    chk("R5 start cleared by data read", {15'd0, req_rx}, 16'd0);
  endtask

  task automatic t_clear_rules();
    rx_sel = 2'b00; st_rx_full = 1; step(); st_rx_full = 0;
    chk("R3 full under 00", {15'd0, req_rx}, 16'd1);
    acc_rd_err = 1; step(); acc_rd_err = 0;
    chk("R4 full kept on error read", {15'd0, req_rx}, 16'd1);
    acc_rd_data = 1; step(); acc_rd_data = 0;
    chk("R4 full cleared by data read", {15'd0, req_rx}, 16'd0);
    st_rx_err = 1; step(); st_rx_err = 0;
    acc_rd_data = 1; step(); acc_rd_data = 0;
    chk("R4 error kept on data read", {15'd0, req_rx}, 16'd1);
    acc_rd_err = 1; step(); acc_rd_err = 0;
    chk("R4 error cleared by error read", {15'd0, req_rx}, 16'd0);
  endtask

  task automatic t_tx();
    st_tx_empty = 1; step();
    chk("R6 tx set", {15'd0, req_tx}, 16'd1);
    chk("R1 tx vector", vector, vx(6'b001000));
    acc_wr_data = 1; step(); acc_wr_data = 0;
    chk("R6 tx cleared by write", {15'd0, req_tx}, 16'd0);
    step(); step();
    chk("R11 held empty does not reset", {15'd0, req_tx}, 16'd0);
    st_tx_empty = 0; step();
  endtask

  task automatic t_lta();
    st_end_seq = 1; step(); st_end_seq = 0;
    chk("R8 lta set", {15'd0, req_lta}, 16'd1);
    chk("R1 lta vector", vector, vx(6'b001100));
    acc_lta_w1c = 1; step(); acc_lta_w1c = 0;
    chk("R8 lta cleared by w1c", {15'd0, req_lta}, 16'd0);
    st_end_seq = 1; step(); st_end_seq = 0;
    acc_wr_data = 1; step(); acc_wr_data = 0;
    chk("R8 lta cleared by write", {15'd0, req_lta}, 16'd0);
  endtask

  task automatic t_filter();
    addr_filter_en = 1; addr_match = 0;
    st_end_seq = 1; step(); st_end_seq = 0; step();
    chk("R9 lta blocked without match", {15'd0, req_lta}, 16'd0);
    chk("R9 irq quiet", {15'd0, irq}, 16'd0);
    addr_match = 1; st_end_seq = 1; step(); st_end_seq = 0;
    chk("R9 lta set with match", {15'd0, req_lta}, 16'd1);
    acc_lta_w1c = 1; step(); acc_lta_w1c = 0;
    addr_filter_en = 0; addr_match = 0;
  endtask

  task automatic t_priority();
    rx_sel = 2'b00; st_rx_full = 1; st_end_seq = 1; step();
    st_rx_full = 0; st_end_seq = 0;
    chk("R1 rx over lta", vector, vx(6'b000100));
    acc_rd_data = 1; step(); acc_rd_data = 0;
    chk("R1 lta after rx serviced", vector, vx(6'b001100));
    st_tx_empty = 1; step(); st_tx_empty = 0;
    chk("R1 tx over lta", vector, vx(6'b001000));
    ibase = 8'h3C; #1;
    chk("R2 base follows input", vector, vx(6'b001000));
    acc_wr_data = 1; step(); acc_wr_data = 0;
    chk("R2 idle after all cleared", {irq, vector[14:0]}, 16'd0);
  endtask

  task automatic t_race();
    rx_sel = 2'b00; st_rx_full = 1; acc_rd_data = 1; step();
    st_rx_full = 0; acc_rd_data = 0;
    chk("R10 rx set beats data read", {15'd0, req_rx}, 16'd1);
    acc_rd_data = 1; step(); acc_rd_data = 0;
    st_end_seq = 1; acc_lta_w1c = 1; step(); st_end_seq = 0; acc_lta_w1c = 0;
    chk("R10 lta set beats w1c", {15'd0, req_lta}, 16'd1);
    acc_lta_w1c = 1; step(); acc_lta_w1c = 0;
  endtask

  task automatic t_xrst();
    rx_sel = 2'b00; st_rx_full = 1; st_end_seq = 1; step();
    st_rx_full = 0; st_end_seq = 0;
    xcvr_rst = 1; step(); xcvr_rst = 0;
    chk("R7 rx cleared", {15'd0, req_rx}, 16'd0);
    chk("R7 lta cleared", {15'd0, req_lta}, 16'd0);
    chk("R7 tx forced", {15'd0, req_tx}, 16'd1);
    st_rx_err = 1; xcvr_rst = 1; step(); st_rx_err = 0; xcvr_rst = 0;
    chk("R7 reset beats set", {15'd0, req_rx}, 16'd0);
    acc_wr_data = 1; step(); acc_wr_data = 0;
    chk("R6 tx cleared after reset", {15'd0, req_tx}, 16'd0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1; step();
    t_reset();
    t_select();
    t_clear_rules();
    t_tx();
    t_lta();
    t_filter();
    t_priority();
    t_race();
    t_xrst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule